// File: doc/BRIEF.md
# Masked Fast GPIO Port

This block is a 32-pin general-purpose I/O port with a register interface on the bus side. It holds an output-value register, a direction register and a per-pin mask register. Software can change the output value in three ways. A direct pin-value write loads every permitted bit in one access. A set write turns selected bits on. A clear write turns selected bits off. Each of these writes can touch only pins whose mask bit is 0, so one driver can own a subset of the port without disturbing the other pins.

Reads of the pin-value register return the physical pin levels after a two-stage synchronizer, with masked pins forced to 0. Four byte-lane enables on every write give byte-wide and half-word-wide access to the same registers. A byte or half-word access places its data in the lanes it covers and enables only those lanes. The output register drives the pins directly, and the direction register drives the per-pin output enables.

Top module: `gpio_mport`

## Requirements
- R1: While reset is asserted (active-low `rst_n`) the output-value, direction and mask registers and both synchronizer stages are 0, so `pin_out`, `pin_oe` and every register read are 0.
- R2: Bit n of each register belongs to pin n, for n from 0 to 31. `pin_out[n]` drives the pin high when the output bit is 1 and low when it is 0. `pin_oe[n]` is 1 when the direction bit is 1, which makes the pin an output.
- R3: A write to select 2 (pin value) gives every unmasked bit in an enabled lane the written value, in the cycle after the write.
- R4: A pin-value, set or clear write leaves unchanged every output bit whose mask bit is 1.
- R5: A write to select 3 (set) makes each unmasked, lane-enabled output bit 1 where the write data is 1. Bits where the data is 0 keep their value.
- R6: A write to select 4 (clear) makes each unmasked, lane-enabled output bit 0 where the write data is 1. Bits where the data is 0 keep their value.
- R7: A read of select 2 returns the synchronized pin level for each pin whose mask bit is 0, and returns 0 for each pin whose mask bit is 1.
- R8: A change on `pin_in` at the inputs before clock edge k appears in the select-2 read data after edge k+1, that is, two clocks later.
- R9: `bus_be[k]` enables bits 8k+7 to 8k of a write. A lane whose enable is 0 keeps its previous value in every register. This covers byte access (one enable set) and half-word access (enables 0011 or 1100).
- R10: Writes to select 0 (direction) and select 1 (mask) store the lane-enabled bits. Reads of selects 0 and 1 return the register contents.
- R11: When `bus_we` is 0, no register changes. A write to selects 5, 6 or 7 changes nothing. A read of select 3 returns the output register, and a read of selects 4 to 7 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_addr | input | 3 | Register select |
| bus_be | input | 4 | Byte-lane write enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register (combinational) |
| pin_in | input | 32 | Physical pin levels, asynchronous |
| pin_out | output | 32 | Output drive value per pin |
| pin_oe | output | 32 | Output enable per pin |

## Verification
The assertions assume that the bus inputs are stable across each rising edge. They also assume that `pin_in` is sampled only through the synchronizer, so a pin may change at any time. The bench changes every input at the falling edge.

The bench covers every value of `bus_addr`, including the three unused codes, and every pattern of `bus_be`, because the properties must hold for all of them. Random pin activity runs at the same time as register traffic. The masked-bit checks therefore compare against a mask that is itself being rewritten lane by lane.

// File: rtl/gpio_mport_pkg.sv
package gpio_mport_pkg;

    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_DIR  = 3'd0,
        SEL_MASK = 3'd1,
        SEL_PIN  = 3'd2,
        SEL_SET  = 3'd3,
        SEL_CLR  = 3'd4
    } sel_e;

endpackage

// File: rtl/gpio_lane_expand.sv
// Turns one enable per byte lane into a per-bit enable.
module gpio_lane_expand #(
    parameter int PORT_W = 32,
    localparam int LANES = PORT_W / 8
) (
    input  logic [LANES-1:0]  lane_en,
    output logic [PORT_W-1:0] bit_en
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign bit_en[g*8 +: 8] = {8{lane_en[g]}};
    end
endmodule

// File: rtl/gpio_sync.sv
// A chain of flops that carries the asynchronous pin levels into the clock domain.
module gpio_sync #(
    parameter int PORT_W = 32,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] async_in,
    output logic [PORT_W-1:0] sync_out
);
    logic [STAGES-1:0][PORT_W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_mport_regs.sv
// Output, direction and mask registers, with mask and lane gating on writes.
module gpio_mport_regs
    import gpio_mport_pkg::*;
#(
    parameter int PORT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  sel_e              wr_sel,
    input  logic [PORT_W-1:0] lane_bits,
    input  logic [PORT_W-1:0] wr_data,
    output logic [PORT_W-1:0] out_q,
    output logic [PORT_W-1:0] dir_q,
    output logic [PORT_W-1:0] mask_q
);
    typedef struct packed {
        logic [PORT_W-1:0] outv;
        logic [PORT_W-1:0] dir;
        logic [PORT_W-1:0] mask;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        logic [PORT_W-1:0] reach;
        logic [PORT_W-1:0] hit;
        st_d  = st_q;
        reach = lane_bits & ~st_q.mask;
        hit   = wr_data & reach;
        if (wr_en) begin
            case (wr_sel)
                SEL_DIR:  st_d.dir  = (st_q.dir & ~lane_bits) | (wr_data & lane_bits);
                SEL_MASK: st_d.mask = (st_q.mask & ~lane_bits) | (wr_data & lane_bits);
                SEL_PIN:  st_d.outv = (st_q.outv & ~reach) | hit;
                SEL_SET:  st_d.outv = st_q.outv | hit;
                SEL_CLR:  st_d.outv = st_q.outv & ~hit;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_q  = st_q.outv;
    assign dir_q  = st_q.dir;
    assign mask_q = st_q.mask;
endmodule

// File: rtl/gpio_mport.sv
module gpio_mport
    import gpio_mport_pkg::*;
#(
    parameter int PORT_W      = 32,
    parameter int SYNC_STAGES = 2,
    localparam int LANES      = PORT_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [SEL_W-1:0]  bus_addr,
    input  logic [LANES-1:0]  bus_be,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe
);
    logic [PORT_W-1:0] lane_bits;
    logic [PORT_W-1:0] pin_sync;
    logic [PORT_W-1:0] out_q, dir_q, mask_q;

    gpio_lane_expand #(.PORT_W(PORT_W)) u_lanes (
        .lane_en (bus_be),
        .bit_en  (lane_bits)
    );

    gpio_sync #(.PORT_W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_mport_regs #(.PORT_W(PORT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_we),
        .wr_sel    (sel_e'(bus_addr)),
        .lane_bits (lane_bits),
        .wr_data   (bus_wdata),
        .out_q     (out_q),
        .dir_q     (dir_q),
        .mask_q    (mask_q)
    );

    always_comb begin
        case (bus_addr)
            SEL_DIR:  bus_rdata = dir_q;
            SEL_MASK: bus_rdata = mask_q;
            SEL_PIN:  bus_rdata = pin_sync & ~mask_q;
            SEL_SET:  bus_rdata = out_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign pin_out = out_q;
    assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_mport_chk.sv
module gpio_mport_chk #(
    parameter int PORT_W = 32,
    localparam int LANES = PORT_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [2:0]        bus_addr,
    input logic [LANES-1:0]  bus_be,
    input logic [PORT_W-1:0] bus_wdata,
    input logic [PORT_W-1:0] bus_rdata,
    input logic [PORT_W-1:0] pin_out,
    input logic [PORT_W-1:0] pin_oe,
    input logic [PORT_W-1:0] mask_q
);
    logic [PORT_W-1:0] be_bits;
    logic              out_wr;

    always_comb begin
        for (int i = 0; i < PORT_W; i++) be_bits[i] = bus_be[i/8];
    end

    assign out_wr = bus_we && (bus_addr == 3'd2 || bus_addr == 3'd3 || bus_addr == 3'd4);

    // R4: bits under the mask keep their value through output writes
    a_r4_masked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr |=> (((pin_out ^ $past(pin_out)) & $past(mask_q)) == '0));

    // R5: a set write never lowers a bit
    a_r5_set_only_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 3'd3) |=> ((~pin_out & $past(pin_out)) == '0));

    // R6: a clear write never raises a bit
    a_r6_clr_only_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 3'd4) |=> ((pin_out & ~$past(pin_out)) == '0));

    // R7: pin-value reads show 0 on masked pins
    a_r7_masked_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 3'd2) |-> ((bus_rdata & mask_q) == '0));

    // R9: a lane without an enable keeps its direction bits
    a_r9_lane_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 3'd0) |=> (((pin_oe ^ $past(pin_oe)) & ~$past(be_bits)) == '0));

    // R11: with no write strobe, nothing that drives the pins changes
    a_r11_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ($stable(pin_out) && $stable(pin_oe)));
endmodule

bind gpio_mport gpio_mport_chk #(.PORT_W(PORT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .mask_q    (mask_q)
);

// File: tb/sim_gpio_mport.sv
module sim_gpio_mport;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // behavioural reference state
    bit [31:0] m_out, m_dir, m_mask;
    bit [31:0] pin_hist[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_mport u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    function automatic bit [31:0] lanes(input bit [3:0] be);
        bit [31:0] r = '0;
        for (int i = 0; i < 32; i++) r[i] = be[i/8];
        return r;
    endfunction

    function automatic bit [31:0] synced();
        return (pin_hist.size() >= 2) ? pin_hist[pin_hist.size()-2] : 32'h0;
    endfunction

    function automatic bit [31:0] exp_read(input bit [2:0] a);
        case (a)
            3'd0: return m_dir;
            3'd1: return m_mask;
            3'd2: return synced() & ~m_mask;
            3'd3: return m_out;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input bit [31:0] got, input bit [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic string op_tag(input bit we, input bit [2:0] a);
        if (!we) return "R11";
        case (a)
            3'd2: return "R3";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd0, 3'd1: return "R10";
            default: return "R11";
        endcase
    endfunction

    string last_tag = "R1";
    string rd_tag   = "";

    // one step: check the state after the last edge, then drive the next vector
    task automatic step(input bit we, input bit [2:0] a, input bit [3:0] be,
                        input bit [31:0] d, input bit [31:0] pins);
        bit [31:0] lb, reach, hit;
        @(negedge clk);
        chk(last_tag, "pin_out R2", pin_out, m_out);
        chk(last_tag, "pin_oe R2", pin_oe, m_dir);
        chk((rd_tag != "") ? rd_tag : ((bus_addr == 3'd2) ? "R7" : "R10"),
            "bus_rdata", bus_rdata, exp_read(bus_addr));
        bus_we = we; bus_addr = a; bus_be = be; bus_wdata = d; pin_in = pins;
        last_tag = op_tag(we, a);
        if (rst_n) begin
            lb = lanes(be);
            reach = lb & ~m_mask;
            hit = d & reach;
            if (we) begin
                case (a)
                    3'd0: m_dir  = (m_dir & ~lb) | (d & lb);
                    3'd1: m_mask = (m_mask & ~lb) | (d & lb);
                    3'd2: m_out  = (m_out & ~reach) | hit;
                    3'd3: m_out  = m_out | hit;
                    3'd4: m_out  = m_out & ~hit;
                    default: ;
                endcase
            end
            pin_hist.push_back(pins);
            if (pin_hist.size() > 4) void'(pin_hist.pop_front());
        end
    endtask

    initial begin
        m_out = '0; m_dir = '0; m_mask = '0;
        repeat (3) @(negedge clk);
        // R1: reset state across all register reads
        for (int a = 0; a < 8; a++) begin
            bus_addr = a[2:0];
            #1;
            chk("R1", "reset rdata", bus_rdata, 32'h0);
        end
        chk("R1", "reset pin_out", pin_out, 32'h0);
        chk("R1", "reset pin_oe", pin_oe, 32'h0);
        bus_addr = 3'd2;
        pin_in = 32'hFFFF_FFFF;
        #1;
        chk("R1", "reset sync", bus_rdata, 32'h0);
        pin_in = '0;
        rst_n = 1'b1;

        // R10 and R2: direction and pin-value word writes
        step(1, 3'd0, 4'hF, 32'hFFFF_0000, 32'h0);
        step(1, 3'd2, 4'hF, 32'hA5A5_1234, 32'h0);
        step(0, 3'd0, 4'h0, 32'h0, 32'h0);
        // R4: mask the second byte, then pin-value, set and clear writes
        step(1, 3'd1, 4'hF, 32'h0000_FF00, 32'h0);
        last_tag = "R4";
        step(1, 3'd2, 4'hF, 32'hFFFF_FFFF, 32'h0);
        last_tag = "R4";
        step(1, 3'd4, 4'hF, 32'hFFFF_FFFF, 32'h0);
        last_tag = "R4";
        step(1, 3'd3, 4'hF, 32'h0F0F_0F0F, 32'h0);
        last_tag = "R4";
        step(0, 3'd3, 4'h0, 32'h0, 32'h0);
        // R9: byte alias on the mask, half-word alias on the pin value
        step(1, 3'd1, 4'b0001, 32'h0000_00FF, 32'h0);
        last_tag = "R9";
        step(1, 3'd2, 4'b1100, 32'h1234_5678, 32'h0);
        last_tag = "R9";
        step(1, 3'd0, 4'b0010, 32'h0000_AA00, 32'h0);
        last_tag = "R9";
        step(1, 3'd1, 4'h0, 32'h0, 32'h0);
        // R8: a pin edge reaches the read path after two clocks
        step(1, 3'd1, 4'hF, 32'h0, 32'h0);
        rd_tag = "R8";
        step(0, 3'd2, 4'h0, 32'h0, 32'hDEAD_BEEF);
        step(0, 3'd2, 4'h0, 32'h0, 32'hDEAD_BEEF);
        step(0, 3'd2, 4'h0, 32'h0, 32'hDEAD_BEEF);
        step(0, 3'd2, 4'h0, 32'h0, 32'h0);
        step(0, 3'd2, 4'h0, 32'h0, 32'h0);
        rd_tag = "R7";
        step(1, 3'd1, 4'hF, 32'hFF00_00FF, 32'hFFFF_FFFF);
        step(0, 3'd2, 4'h0, 32'h0, 32'hFFFF_FFFF);
        step(0, 3'd2, 4'h0, 32'h0, 32'hFFFF_FFFF);
        rd_tag = "";
        // R11: idle strobe and unused selects
        step(0, 3'd2, 4'hF, 32'hFFFF_FFFF, 32'h0);
        step(1, 3'd5, 4'hF, 32'hFFFF_FFFF, 32'h0);
        step(1, 3'd7, 4'hF, 32'hFFFF_FFFF, 32'h0);
        step(0, 3'd4, 4'h0, 32'h0, 32'h0);
        // mixed traffic across all selects and lane patterns
        for (int i = 0; i < 400; i++) begin
            step(($urandom % 4) != 0, 3'($urandom), 4'($urandom), $urandom, $urandom);
        end
        step(0, 3'd2, 4'h0, 32'h0, 32'h0);
        step(0, 3'd2, 4'h0, 32'h0, 32'h0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule